// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator

This block is a serial test-pattern source that runs on its own pattern clock. It drives one bit per rising edge. That bit comes from one of three maximal-length pseudo-random sequences or from a 10-bit pattern chosen by software that repeats. The output can be inverted, and the generator can be enabled or stopped.

The inputs come from registers in another clock domain:
- a 4-bit mode word;
- three nibbles that together hold the user pattern;
- a load bit.

The mode word and the load bit cross into the pattern-clock domain through a two-flop synchronizer. The nibbles are treated as quasi-static. They are sampled only while the synchronized load bit is high. The sampled pattern goes live when the load bit falls, and the user sequence then restarts at its first bit.

Top module: `prbs_pattern_gen`

## Requirements
- R1: After reset, `data_o` is 0, every LFSR holds all ones, and the active user pattern is all zeros. If user mode is enabled before any load, the output is 0.
- R2: With `mode_i[3:2]=00`, the output follows x^7+x^6+1: the first 7 bits after reset are 1, s(t)=s(t-7)^s(t-6), and the period is 127.
- R3: With `mode_i[3:2]=01`, the output follows x^10+x^7+1: the first 10 bits are 1, s(t)=s(t-10)^s(t-7), and the period is 1023.
- R4: With `mode_i[3:2]=10`, the output follows x^23+x^18+1: the first 23 bits are 1 and s(t)=s(t-23)^s(t-18).
- R5: With `mode_i[3:2]=11`, the active 10-bit user pattern is sent bit 0 first. It repeats every 10 enabled clocks.
- R6: `mode_i[1]=1` inverts the output bit in every pattern mode.
- R7: With `mode_i[0]=0`, the output is 0 and the state of every sequence is held. Each sequence resumes where it stopped when it is enabled again.
- R8: The user pattern is `{upat_hi_i[1:0], upat_mid_i, upat_lo_i}`. `upat_hi_i[3:2]` has no effect.
- R9: Changes to the nibbles while `load_i` is low have no effect. The pattern sampled while `load_i` is high does not affect the output until `load_i` returns to 0. Its bit 0 appears at the fourth sample after the edge on which the low is driven.
- R10: A change of `mode_i` reaches `data_o` on the third rising edge after it is applied: two synchronizer edges plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pattern clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | [3:2] pattern select, [1] invert, [0] enable |
| upat_lo_i | input | 4 | User pattern bits 3..0 |
| upat_mid_i | input | 4 | User pattern bits 7..4 |
| upat_hi_i | input | 4 | User pattern bits 9..8 in [1:0]; [3:2] unused |
| load_i | input | 1 | Load request; the pattern is sampled while high and committed on release |
| data_o | output | 1 | Serial pattern bit, registered on the rising edge |

## Verification
The hardest situation to reach is a new user pattern being committed while the old one is still streaming. This must happen at a point other than the pattern's start, and with the enable being toggled, because the restart index, the held index and the synchronizer delay all interact there. The stimulus loads patterns while the generator is running at a random phase. It holds the load for a random number of cycles and toggles the enable at random. A delayed model of the mode and load inputs in the bench predicts the exact sample at which the first bit of the new pattern appears.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int NUM_LFSR = 3;
  localparam int USER_W   = 10;
  localparam int NIB_W    = 4;

  localparam logic [1:0] SEL_P7   = 2'd0;
  localparam logic [1:0] SEL_P10  = 2'd1;
  localparam logic [1:0] SEL_P23  = 2'd2;
  localparam logic [1:0] SEL_USER = 2'd3;

  typedef struct packed {
    logic [1:0] sel;
    logic       inv;
    logic       en;
  } prbs_mode_t;

  function automatic int lfsr_len(int i);
    case (i)
      0:       return 7;
      1:       return 10;
      default: return 23;
    endcase
  endfunction

  function automatic int lfsr_tap(int i);
    case (i)
      0:       return 6;
      1:       return 7;
      default: return 18;
    endcase
  endfunction

endpackage

// File: rtl/prbs_sync.sv
module prbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/prbs_lfsr.sv
module prbs_lfsr #(
  parameter int W   = 7,
  parameter int TAP = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic bit_o
);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = state_q[W-1] ^ state_q[TAP-1];
  assign bit_o = state_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '1;
    else if (adv_i) state_q <= {state_q[W-2:0], fb};
  end

  a_r2_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  a_r7_hold_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));

endmodule

// File: rtl/prbs_user_seq.sv
module prbs_user_seq #(
  parameter int PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] staged_i,
  input  logic          load_s_i,
  input  logic          adv_i,
  output logic          bit_o
);

  localparam int IW = $clog2(PW);

  logic [PW-1:0] stage_q;
  logic [PW-1:0] active_q;
  logic [IW-1:0] idx_q;
  logic          load_d_q;
  logic          commit;

  assign commit = load_d_q & ~load_s_i;
  assign bit_o  = active_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      load_d_q <= 1'b0;
    end else begin
      load_d_q <= load_s_i;
      if (load_s_i) stage_q <= staged_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      idx_q    <= '0;
    end else if (commit) begin
      active_q <= stage_q;
      idx_q    <= '0;
    end else if (adv_i) begin
      idx_q <= (idx_q == IW'(PW-1)) ? '0 : idx_q + 1'b1;
    end
  end

  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IW'(PW));

  a_r9_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(active_q));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> idx_q == '0);

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  input  logic [3:0] upat_lo_i,
  input  logic [3:0] upat_mid_i,
  input  logic [3:0] upat_hi_i,
  input  logic       load_i,
  output logic       data_o
);

  localparam int HI_W   = USER_W - 2 * NIB_W;
  localparam int CTRL_W = $bits(prbs_mode_t) + 1;

  logic [CTRL_W-1:0] ctrl_s;
  prbs_mode_t        mode_s;
  logic              load_s;
  logic [USER_W-1:0] staged;
  logic [NUM_LFSR-1:0] lfsr_adv;
  logic [NUM_LFSR-1:0] lfsr_bit;
  logic              user_adv;
  logic              user_bit;
  logic              sel_bit;
  logic              data_q;
  logic              unused_hi;

  prbs_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({load_i, mode_i}),
    .q_o   (ctrl_s)
  );

  assign mode_s = prbs_mode_t'(ctrl_s[CTRL_W-2:0]);
  assign load_s = ctrl_s[CTRL_W-1];

  assign staged    = {upat_hi_i[HI_W-1:0], upat_mid_i, upat_lo_i};
  assign unused_hi = ^upat_hi_i[3:HI_W];

  for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lfsr
    localparam int LW = lfsr_len(g);
    localparam int LT = lfsr_tap(g);
    assign lfsr_adv[g] = mode_s.en && (mode_s.sel == 2'(g));
    prbs_lfsr #(.W(LW), .TAP(LT)) u_lfsr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .adv_i (lfsr_adv[g]),
      .bit_o (lfsr_bit[g])
    );
  end

  assign user_adv = mode_s.en && (mode_s.sel == SEL_USER);

  prbs_user_seq #(.PW(USER_W)) u_user (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .staged_i(staged),
    .load_s_i(load_s),
    .adv_i   (user_adv),
    .bit_o   (user_bit)
  );

  always_comb begin
    case (mode_s.sel)
      SEL_P7:  sel_bit = lfsr_bit[0];
      SEL_P10: sel_bit = lfsr_bit[1];
      SEL_P23: sel_bit = lfsr_bit[2];
      default: sel_bit = user_bit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= 1'b0;
    else if (mode_s.en) data_q <= sel_bit ^ mode_s.inv;
    else                data_q <= 1'b0;
  end

  assign data_o = data_q;

  a_r7_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s.en |=> !data_o);

  a_r5_single_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({user_adv, lfsr_adv}));

endmodule

// File: tb/sim_prbs_pattern_gen.sv
`timescale 1ns/1ps
module sim_prbs_pattern_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] cur_mode = '0;
  logic [3:0] cur_lo = '0, cur_mid = '0, cur_hi = '0;
  logic       cur_load = 1'b0;
  logic       data_o;

  always #5 clk_i = ~clk_i;

  prbs_pattern_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(cur_mode),
    .upat_lo_i(cur_lo), .upat_mid_i(cur_mid), .upat_hi_i(cur_hi),
    .load_i(cur_load), .data_o(data_o)
  );

  int n_err = 0, n_checks = 0;
  logic [3:0] mode_h [0:5];
  logic       ld_h   [0:5];
  logic       hist   [0:2][0:4095];
  int         cnt    [0:2];
  logic [9:0] exp_act, pend;
  int         exp_idx;
  logic       obs [0:4095];
  int         obs_n;
  logic       last_q;
  string      tag_ovr = "";

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      if (n_err < 20) $display("FAIL %s: data_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lag_w(int k);
    return (k == 0) ? 7 : (k == 1) ? 10 : 23;
  endfunction
  function automatic int lag_t(int k);
    return (k == 0) ? 6 : (k == 1) ? 7 : 18;
  endfunction

  function automatic logic gen_next(int k);
    int n = cnt[k];
    logic b;
    b = (n < lag_w(k)) ? 1'b1 : hist[k][n - lag_w(k)] ^ hist[k][n - lag_t(k)];
    hist[k][n] = b;
    cnt[k] = n + 1;
    return b;
  endfunction

  task automatic step();
    logic [3:0] m;
    logic raw, exp;
    string tag;
    @(negedge clk_i);
    for (int k = 5; k > 0; k--) begin
      mode_h[k] = mode_h[k-1];
      ld_h[k]   = ld_h[k-1];
    end
    mode_h[0] = cur_mode;
    ld_h[0]   = cur_load;
    if (!ld_h[3] && ld_h[4]) begin
      exp_act = pend;
      exp_idx = 0;
    end
    m = mode_h[2];
    if (!m[0]) begin
      exp = 1'b0; tag = "R7";
    end else begin
      if (m[3:2] == 2'b11) begin
        raw = exp_act[exp_idx];
        exp_idx = (exp_idx + 1) % 10;
        tag = "R5";
      end else begin
        raw = gen_next(int'(m[3:2]));
        tag = (m[3:2] == 2'b00) ? "R2" : (m[3:2] == 2'b01) ? "R3" : "R4";
      end
      exp = raw ^ m[1];
      if (m[1]) tag = "R6";
    end
    if (tag_ovr != "") tag = tag_ovr;
    check(data_o, exp, tag);
    last_q = data_o;
    if (m[0] && obs_n < 4096) begin
      obs[obs_n] = data_o;
      obs_n++;
    end
  endtask

  task automatic do_reset();
    cur_mode = '0;
    cur_load = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check(data_o, 1'b0, "R1");
    rst_ni = 1'b1;
    for (int k = 0; k < 6; k++) begin mode_h[k] = '0; ld_h[k] = 1'b0; end
    for (int k = 0; k < 3; k++) cnt[k] = 0;
    exp_act = '0; exp_idx = 0; obs_n = 0;
  endtask

  task automatic load_pat(input logic [3:0] lo, input logic [3:0] mid,
                          input logic [3:0] hi, input int hold);
    cur_lo = lo; cur_mid = mid; cur_hi = hi;
    cur_load = 1'b1;
    pend = {hi[1:0], mid, lo};
    repeat (hold) step();
    cur_load = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_err++;
    n_checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    repeat (4) step();

    // R10 and R2: enable the 7-bit sequence, check latency then the stream
    cur_mode = 4'b0001;
    step(); step();
    check(last_q, 1'b0, "R10");
    step();
    check(last_q, 1'b1, "R10");
    repeat (300) step();
    for (int t = 0; t < 100; t++) check(obs[t + 127], obs[t], "R2");

    // R3
    do_reset();
    cur_mode = 4'b0101;
    repeat (1110) step();
    for (int t = 0; t < 60; t++) check(obs[t + 1023], obs[t], "R3");

    // R4
    do_reset();
    cur_mode = 4'b1001;
    repeat (300) step();

    // R6: inverted 7-bit sequence, begins with zeros
    do_reset();
    cur_mode = 4'b0011;
    repeat (3) step();
    check(last_q, 1'b0, "R6");
    repeat (200) step();

    // R7: random stop/start on the 10-bit sequence
    do_reset();
    for (int r = 0; r < 400; r++) begin
      cur_mode = {3'b010, 1'($urandom_range(0, 3) != 0)};
      step();
    end

    // R1: user mode before any load yields zeros
    do_reset();
    tag_ovr = "R1";
    cur_mode = 4'b1101;
    repeat (20) step();
    check(last_q, 1'b0, "R1");
    tag_ovr = "";

    // R5: directed patterns
    do_reset();
    load_pat(4'h1, 4'h0, 4'h0, 3);
    repeat (6) step();
    cur_mode = 4'b1101;
    repeat (40) step();
    load_pat(4'hF, 4'hF, 4'h3, 2);
    repeat (40) step();
    load_pat(4'h0, 4'h0, 4'h0, 1);
    repeat (30) step();

    // R9: nibble changes with load low are ignored
    load_pat(4'hA, 4'h5, 4'h2, 2);
    repeat (15) step();
    tag_ovr = "R9";
    cur_lo = 4'h3; cur_mid = 4'hC; cur_hi = 4'h1;
    repeat (30) step();
    // held load: old pattern continues until release
    load_pat(4'h6, 4'h9, 4'h1, 25);
    repeat (30) step();
    tag_ovr = "";

    // R8 with R6/R7: random patterns, dirty high bits, random phase and enable
    tag_ovr = "R8";
    for (int r = 0; r < 8; r++) begin
      load_pat(4'($urandom), 4'($urandom), 4'($urandom), 1 + $urandom_range(0, 4));
      for (int c = 0; c < 60; c++) begin
        cur_mode = {2'b11, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) != 0)};
        step();
      end
    end
    tag_ovr = "";
    cur_mode = 4'b0000;
    repeat (4) step();

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule